// File: doc/BRIEF.md
# Serial Transmit FIFO with Status and Interrupts

This block is the transmit half of a synchronous serial port. The processor fills a small word FIFO through a register-write strobe. When a transmit frame sync arrives, the word at the head of the FIFO moves into a shift register, which then drives one bit per bit-clock enable on the serial output, most significant bit first. Frame-sync generation and bit-clock division happen outside this block. Both arrive here as single-cycle strobes in the system clock domain.

The block keeps three status flags: full, overflow and underflow. It also drives two interrupt lines: a service request that asks for more data, and an error line. Overflow is sticky and clears only when the transmitter is turned off. Underflow is sticky, is cleared by writing 1 to its status bit, and also clears when the transmitter is turned off. FIFO writes, the full flag and the overflow flag keep working while the transmitter is off, so software can preload words before it enables the port. In multichannel operation, a frame sync starts a word only in an enabled slot.

Top module: `sertx_port`

## Requirements
- R1: While the FIFO holds fewer than DEPTH words, a write stores the word whether or not `tx_en` is set. Stored words are transmitted in the order they were written.
- R2: `stat_full` is 1 exactly when the FIFO holds DEPTH words, and 0 whenever there is space for another word.
- R3: A write to a full FIFO discards the incoming word, leaves the stored words unchanged and sets `stat_ovf` on the next cycle. This also applies while `tx_en` is 0.
- R4: `stat_ovf` stays set until the clock edge that follows a 1-to-0 change of `tx_en`. Writing 1 to status bit 1 has no effect on it. If a new overflow occurs in the same cycle as that clear, the flag stays set.
- R5: A transmit start is `fsync` high while `tx_en` is 1, and also `slot_en` is 1 when `mc_mode` is 1. When a transmit start finds the FIFO non-empty, the head word is popped into the shift register. `sdo` always shows the shift register's MSB. Each `bit_ce` while `tx_en` is 1 shifts the register left by one and fills a 0. A load in the same cycle takes priority over the shift.
- R6: A transmit start that finds the FIFO empty sets `stat_uvf`. It also reloads the shift register with the last word loaded from the FIFO, or with 0 if no word has been loaded since reset.
- R7: When `mc_mode` is 1 and `slot_en` is 0, `fsync` neither loads the shift register nor sets `stat_uvf`.
- R8: `stat_uvf` clears on a status write with bit 0 set. It also clears at the clock edge that follows a 1-to-0 change of `tx_en`. If a new underflow occurs in the same cycle as a clearing write, the flag stays set.
- R9: `irq_tx` is high exactly when `tx_en` is 1, `dma_en` is 0 and the FIFO is not full.
- R10: `irq_err` is high exactly while `stat_ovf` or `stat_uvf` is set.
- R11: After reset, the FIFO is empty, all flags are 0, the shift register holds 0 and `sdo` is 0.
- R12: A write and a transmit start in the same cycle are both judged on the FIFO contents before that cycle. If the FIFO was empty, the start underflows and the written word is kept. If the FIFO was full, the write is dropped and `stat_ovf` is set even though a word leaves the FIFO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_en | input | 1 | Transmit enable |
| dma_en | input | 1 | DMA mode; suppresses `irq_tx` |
| mc_mode | input | 1 | Multichannel mode select |
| slot_en | input | 1 | Current slot is an enabled channel |
| wr_valid | input | 1 | Processor write strobe for the data register |
| wr_data | input | WORD_W | Word to enqueue |
| stat_wr | input | 1 | Processor write strobe for the status register |
| stat_wdata | input | 2 | Status write data: bit 0 clears underflow, bit 1 has no effect |
| fsync | input | 1 | Transmit frame-sync strobe |
| bit_ce | input | 1 | Bit-clock enable for the shift register |
| sdo | output | 1 | Serial data out, MSB first |
| stat_full | output | 1 | FIFO full flag |
| stat_ovf | output | 1 | Sticky overflow flag |
| stat_uvf | output | 1 | Sticky underflow flag |
| irq_tx | output | 1 | Transmit service request |
| irq_err | output | 1 | Error interrupt, level |

## Verification
The key overlap is a processor write and a transmit start landing in the same clock cycle. This is provoked on an empty FIFO, which must underflow and still keep the new word. It is also provoked on a full FIFO, which must drop the word and raise overflow even though a word leaves in that same cycle. A second overlap is a status clear meeting a new underflow, or a disable meeting a new overflow. In both cases the set must win. The bench checks these cases with directed steps. It then sweeps all eight combinations of enable, DMA and multichannel mode with dense random traffic. A cycle-level model computes the expected FIFO contents, shift register and flags, and the bench compares them every cycle.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

    // Status register write bit positions
    localparam int STW_CLR_UVF = 0;
    localparam int STW_OVF     = 1;
    localparam int STW_W       = 2;

    typedef enum logic [1:0] {
        SH_HOLD,
        SH_SHIFT,
        SH_LOAD,
        SH_RELOAD
    } sh_op_e;

    typedef struct packed {
        logic uvf;
        logic ovf;
    } err_flags_t;

    // Set has priority over clear
    function automatic logic sticky_next(input logic cur, input logic set, input logic clr);
        return set | (cur & ~clr);
    endfunction

endpackage

// File: rtl/sertx_fifo.sv
module sertx_fifo #(
    parameter int WORD_W = 16,
    parameter int DEPTH  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  logic [WORD_W-1:0] push_data,
    input  logic              pop,
    output logic [WORD_W-1:0] head,
    output logic              full,
    output logic              empty
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [WORD_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  rd_ptr, wr_ptr;
    logic [CNT_W-1:0]  count;

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full  = (count == CNT_W'(DEPTH));
    assign empty = (count == '0);
    assign head  = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= ptr_inc(wr_ptr);
            if (pop)  rd_ptr <= ptr_inc(rd_ptr);
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/sertx_shifter.sv
module sertx_shifter
    import sertx_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  sh_op_e            op,
    input  logic [WORD_W-1:0] load_data,
    output logic              sdo
);
    logic [WORD_W-1:0] shreg;
    logic [WORD_W-1:0] last_word;

    assign sdo = shreg[WORD_W-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg     <= '0;
            last_word <= '0;
        end else begin
            case (op)
                SH_LOAD: begin
                    shreg     <= load_data;
                    last_word <= load_data;
                end
                SH_RELOAD: shreg <= last_word;
                SH_SHIFT:  shreg <= {shreg[WORD_W-2:0], 1'b0};
                default:   shreg <= shreg;
            endcase
        end
    end
endmodule

// File: rtl/sertx_status.sv
module sertx_status
    import sertx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tx_en,
    input  logic              ovf_set,
    input  logic              uvf_set,
    input  logic              stat_wr,
    input  logic [STW_W-1:0]  stat_wdata,
    output err_flags_t        flags
);
    logic tx_en_q;
    logic disable_edge;
    logic uvf_w1c;

    assign disable_edge = tx_en_q & ~tx_en;
    // Overflow bit ignores writes; only underflow is write-1-to-clear
    assign uvf_w1c      = stat_wr & stat_wdata[STW_CLR_UVF];

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_en_q <= 1'b0;
            flags   <= '0;
        end else begin
            tx_en_q   <= tx_en;
            flags.ovf <= sticky_next(flags.ovf, ovf_set, disable_edge);
            flags.uvf <= sticky_next(flags.uvf, uvf_set, disable_edge | uvf_w1c);
        end
    end
endmodule

// File: rtl/sertx_port.sv
module sertx_port
    import sertx_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int DEPTH  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tx_en,
    input  logic              dma_en,
    input  logic              mc_mode,
    input  logic              slot_en,
    input  logic              wr_valid,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              stat_wr,
    input  logic [1:0]        stat_wdata,
    input  logic              fsync,
    input  logic              bit_ce,
    output logic              sdo,
    output logic              stat_full,
    output logic              stat_ovf,
    output logic              stat_uvf,
    output logic              irq_tx,
    output logic              irq_err
);
    logic              fifo_full, fifo_empty;
    logic [WORD_W-1:0] fifo_head;
    logic              push, pop, tx_start;
    logic              ovf_set, uvf_set;
    sh_op_e            sh_op;
    err_flags_t        flags;

    // Write and start are both judged on the registered occupancy
    assign push     = wr_valid & ~fifo_full;
    assign ovf_set  = wr_valid & fifo_full;
    assign tx_start = fsync & tx_en & (~mc_mode | slot_en);
    assign pop      = tx_start & ~fifo_empty;
    assign uvf_set  = tx_start & fifo_empty;

    always_comb begin
        if (tx_start)
            sh_op = fifo_empty ? SH_RELOAD : SH_LOAD;
        else if (bit_ce & tx_en)
            sh_op = SH_SHIFT;
        else
            sh_op = SH_HOLD;
    end

    sertx_fifo #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_fifo (
        .clk       (clk),
        .rst       (rst),
        .push      (push),
        .push_data (wr_data),
        .pop       (pop),
        .head      (fifo_head),
        .full      (fifo_full),
        .empty     (fifo_empty)
    );

    sertx_shifter #(.WORD_W(WORD_W)) u_shift (
        .clk       (clk),
        .rst       (rst),
        .op        (sh_op),
        .load_data (fifo_head),
        .sdo       (sdo)
    );

    sertx_status u_stat (
        .clk        (clk),
        .rst        (rst),
        .tx_en      (tx_en),
        .ovf_set    (ovf_set),
        .uvf_set    (uvf_set),
        .stat_wr    (stat_wr),
        .stat_wdata (stat_wdata),
        .flags      (flags)
    );

    assign stat_full = fifo_full;
    assign stat_ovf  = flags.ovf;
    assign stat_uvf  = flags.uvf;
    assign irq_tx    = tx_en & ~dma_en & ~fifo_full;
    assign irq_err   = flags.ovf | flags.uvf;
endmodule

// File: rtl/sertx_port_chk.sv
module sertx_port_chk (
    input logic       clk,
    input logic       rst,
    input logic       tx_en,
    input logic       dma_en,
    input logic       mc_mode,
    input logic       slot_en,
    input logic       wr_valid,
    input logic       stat_wr,
    input logic [1:0] stat_wdata,
    input logic       fsync,
    input logic       stat_full,
    input logic       stat_ovf,
    input logic       stat_uvf,
    input logic       irq_tx,
    input logic       irq_err,
    input logic       fifo_empty
);
    // R3
    full_write_ovf_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && stat_full) |=> stat_ovf);

    // R4
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (stat_ovf && tx_en) |=> stat_ovf);

    // R6
    underflow_set_chk: assert property (@(posedge clk) disable iff (rst)
        (fsync && tx_en && (!mc_mode || slot_en) && fifo_empty) |=> stat_uvf);

    // R7
    slot_masked_chk: assert property (@(posedge clk) disable iff (rst)
        (!stat_uvf && mc_mode && !slot_en && !(stat_wr && stat_wdata[0]) && tx_en) |=> !stat_uvf);

    // R8
    uvf_w1c_chk: assert property (@(posedge clk) disable iff (rst)
        (stat_wr && stat_wdata[0] && !fsync) |=> !stat_uvf);

    // R8
    uvf_disable_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_en ##1 !tx_en) |=> !stat_uvf);

    // R9
    irq_tx_dma_chk: assert property (@(posedge clk) disable iff (rst)
        dma_en |-> !irq_tx);

    // R9
    irq_tx_room_chk: assert property (@(posedge clk) disable iff (rst)
        irq_tx |-> (tx_en && !stat_full));

    // R10
    irq_err_level_chk: assert property (@(posedge clk) disable iff (rst)
        irq_err |-> (stat_ovf || stat_uvf));
endmodule

bind sertx_port sertx_port_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .tx_en      (tx_en),
    .dma_en     (dma_en),
    .mc_mode    (mc_mode),
    .slot_en    (slot_en),
    .wr_valid   (wr_valid),
    .stat_wr    (stat_wr),
    .stat_wdata (stat_wdata),
    .fsync      (fsync),
    .stat_full  (stat_full),
    .stat_ovf   (stat_ovf),
    .stat_uvf   (stat_uvf),
    .irq_tx     (irq_tx),
    .irq_err    (irq_err),
    .fifo_empty (fifo_empty)
);

// File: tb/sertx_port_bench.sv
module sertx_port_bench;
    localparam int CLK_PERIOD = 10;
    localparam int W = 16;
    localparam int D = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tx_en = 0, dma_en = 0, mc_mode = 0, slot_en = 0;
    logic wr_valid = 0, stat_wr = 0, fsync = 0, bit_ce = 0;
    logic [W-1:0] wr_data = '0;
    logic [1:0] stat_wdata = '0;
    logic sdo, stat_full, stat_ovf, stat_uvf, irq_tx, irq_err;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    // model state
    logic [W-1:0] m_q [D];
    int           m_cnt = 0;
    logic [W-1:0] m_sh = '0, m_last = '0;
    logic         m_ovf = 0, m_uvf = 0, m_enq = 0;
    logic [31:0]  lf = 32'h1234_5679;

    always #(CLK_PERIOD/2) clk = ~clk;

    sertx_port #(.WORD_W(W), .DEPTH(D)) u_sertx_port (
        .clk(clk), .rst(rst), .tx_en(tx_en), .dma_en(dma_en), .mc_mode(mc_mode),
        .slot_en(slot_en), .wr_valid(wr_valid), .wr_data(wr_data), .stat_wr(stat_wr),
        .stat_wdata(stat_wdata), .fsync(fsync), .bit_ce(bit_ce), .sdo(sdo),
        .stat_full(stat_full), .stat_ovf(stat_ovf), .stat_uvf(stat_uvf),
        .irq_tx(irq_tx), .irq_err(irq_err)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        chk("R2 full", 32'(stat_full), 32'(m_cnt == D));
        chk("R3 R4 ovf", 32'(stat_ovf), 32'(m_ovf));
        chk("R6 R8 uvf", 32'(stat_uvf), 32'(m_uvf));
        chk("R9 irq_tx", 32'(irq_tx), 32'(tx_en & ~dma_en & (m_cnt != D)));
        chk("R10 irq_err", 32'(irq_err), 32'(m_ovf | m_uvf));
        chk("R1 R5 sdo", 32'(sdo), 32'(m_sh[W-1]));
    endtask

    // one cycle: drive at negedge, model the edge, compare at next negedge
    task automatic step(input logic wr, input logic [W-1:0] d, input logic fs,
                        input logic bc, input logic sw, input logic [1:0] sd);
        logic start, fall, oset, uset;
        int   old_cnt;
        wr_valid = wr; wr_data = d; fsync = fs; bit_ce = bc; stat_wr = sw; stat_wdata = sd;
        start   = fs & tx_en & (~mc_mode | slot_en);
        old_cnt = m_cnt;
        oset    = wr && (old_cnt == D);
        uset    = start && (old_cnt == 0);
        fall    = m_enq & ~tx_en;
        if (start) begin
            if (old_cnt > 0) begin
                m_sh = m_q[0]; m_last = m_q[0];
                for (int i = 0; i < D-1; i++) m_q[i] = m_q[i+1];
                m_cnt--;
            end else begin
                m_sh = m_last;
            end
        end else if (bc && tx_en) begin
            m_sh = {m_sh[W-2:0], 1'b0};
        end
        if (wr && old_cnt < D) begin
            m_q[m_cnt] = d;
            m_cnt++;
        end
        m_ovf = oset | (m_ovf & ~fall);
        m_uvf = uset | (m_uvf & ~fall & ~(sw & sd[0]));
        m_enq = tx_en;
        @(posedge clk);
        @(negedge clk);
        compare_all();
    endtask

    function automatic logic [31:0] rnd(input logic [31:0] x);
        logic [31:0] y;
        y = x ^ (x << 13);
        y = y ^ (y >> 17);
        return y ^ (y << 5);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        chk("R11 full", 32'(stat_full), 0);
        chk("R11 ovf", 32'(stat_ovf), 0);
        chk("R11 uvf", 32'(stat_uvf), 0);
        chk("R11 irq_err", 32'(irq_err), 0);
        chk("R11 sdo", 32'(sdo), 0);

        // Preload while disabled (R1, R2, R3)
        for (int k = 1; k <= 4; k++) step(1, 16'hA000 + 16'(k), 0, 0, 0, 0);
        chk("R2 full after DEPTH writes", 32'(stat_full), 1);
        chk("R9 irq_tx off while disabled", 32'(irq_tx), 0);
        step(1, 16'hA005, 0, 0, 0, 0);
        chk("R3 ovf while disabled", 32'(stat_ovf), 1);
        chk("R10 irq_err", 32'(irq_err), 1);
        tx_en = 1;
        step(0, 0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 1, 2'b10);
        chk("R4 ovf ignores write-1", 32'(stat_ovf), 1);
        step(0, 0, 1, 0, 0, 0);
        chk("R5 first word MSB", 32'(sdo), 1);
        chk("R9 irq_tx with room", 32'(irq_tx), 1);
        for (int k = 0; k < W-1; k++) step(0, 0, 0, 1, 0, 0);
        chk("R5 LSB of A001", 32'(sdo), 1);
        tx_en = 0;
        step(0, 0, 0, 0, 0, 0);
        chk("R4 ovf cleared by disable", 32'(stat_ovf), 0);
        tx_en = 1;
        dma_en = 1;
        step(0, 0, 0, 0, 0, 0);
        chk("R9 irq_tx off in DMA", 32'(irq_tx), 0);
        dma_en = 0;

        // Drain and underflow (R1, R6, R8)
        for (int k = 0; k < 3; k++) step(0, 0, 1, 0, 0, 0);
        step(0, 0, 1, 0, 0, 0);
        chk("R6 underflow set", 32'(stat_uvf), 1);
        chk("R6 retransmit last word MSB", 32'(sdo), 1);
        step(0, 0, 0, 0, 1, 2'b01);
        chk("R8 uvf write-1-clear", 32'(stat_uvf), 0);

        // Multichannel masking (R7)
        mc_mode = 1; slot_en = 0;
        step(0, 0, 1, 0, 0, 0);
        chk("R7 masked slot no underflow", 32'(stat_uvf), 0);
        slot_en = 1;
        step(0, 0, 1, 0, 0, 0);
        chk("R7 enabled slot underflows", 32'(stat_uvf), 1);
        step(0, 0, 0, 0, 1, 2'b01);
        mc_mode = 0;

        // Same-cycle write and start (R12)
        step(1, 16'h8000, 1, 0, 0, 0);
        chk("R12 empty start underflows", 32'(stat_uvf), 1);
        step(0, 0, 0, 0, 1, 2'b01);
        step(0, 0, 1, 0, 0, 0);
        chk("R12 word kept and sent", 32'(sdo), 1);
        step(0, 0, 0, 1, 0, 0);
        for (int k = 0; k < 4; k++) step(1, 16'h1111 * 16'(k+1), 0, 0, 0, 0);
        step(1, 16'h7777, 1, 0, 0, 0);
        chk("R12 full write dropped despite pop", 32'(stat_ovf), 1);
        chk("R12 one slot free after pop", 32'(stat_full), 0);
        tx_en = 0;
        step(0, 0, 0, 0, 0, 0);

        // Sweep of all mode combinations with dense random traffic
        for (int m = 0; m < 8; m++) begin
            tx_en = m[0]; dma_en = m[1]; mc_mode = m[2];
            for (int c = 0; c < 600; c++) begin
                lf = rnd(lf);
                slot_en = lf[8];
                if (lf[12:8] == 5'd0) tx_en = ~tx_en;
                step(lf[0] | lf[1], lf[31:16], lf[2] & lf[3], lf[4],
                     lf[5] & lf[6] & lf[7], lf[10:9]);
            end
        end

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule